// File: doc/BRIEF.md
# Lane Stop-State Timeout Detector

This block watches a group of serial receive lanes after software has forced the receiver into receive mode. Each enabled lane must report the low-power stop state without a break for a programmable minimum time. When every enabled lane has done so, the block clears the force flag by itself and emits a one-cycle done pulse. Software or a sequencer sets the flag through a set input and then waits for the flag to drop.

The minimum time is counted in functional clock cycles. It is a programmable count multiplied by two prescale factors, ×16 and ×4, and each factor has its own enable. For a 100 µs minimum with both factors on, the count is the functional clock rate in Hz divided by 640000, rounded up.

Top module: `lane_stop_detect`

## Requirements
- R1: After reset, force_o, done_o and every bit of lane_qual_o are 0.
- R2: A cycle with force_set_i high sets force_o from the next cycle on. Set takes priority over the self-clear, so force_o stays high while force_set_i is held.
- R3: The timeout T in functional clock cycles is max(tmo_count_i,1) × (pre16_en_i ? 16 : 1) × (pre4_en_i ? 4 : 1). Take a set sampled at clock edge E0, with every enabled lane's stop input high from then on. Then force_o is high for exactly T+1 cycles and falls after edge E0+T+1.
- R4: A tmo_count_i of 0 gives the same timeout as a value of 1.
- R5: A lane counts only the cycles in which its stop input is sampled high. One sampled low cycle restarts its count from zero.
- R6: Lanes whose lane_en_i bit is 0 do not take part in the all-lanes decision. With no lane enabled, force_o clears on the first edge at which force_set_i is low.
- R7: done_o is high for exactly one cycle, in the first cycle in which force_o is low after having been high.
- R8: While force_o is low, the lane counters are held at zero and lane_qual_o reads 0. Stop-state time before the set does not count.
- R9: lane_qual_o[i] is 1 while force_o is high and lane i has counted at least T consecutive stop cycles. This holds whether or not lane i is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| force_set_i | input | 1 | Sets the force-receive-mode flag |
| lane_en_i | input | NUM_LANES | Lanes that take part in the decision |
| lane_stop_i | input | NUM_LANES | Per-lane stop-state indication |
| tmo_count_i | input | CNT_W | Programmable timeout count |
| pre16_en_i | input | 1 | Multiply the timeout by 16 |
| pre4_en_i | input | 1 | Multiply the timeout by 4 |
| force_o | output | 1 | Force-receive-mode flag |
| lane_qual_o | output | NUM_LANES | Per-lane qualified stop state |
| done_o | output | 1 | One-cycle pulse when the flag self-clears |

## Verification
The timeout is measured as the number of cycles force_o stays high. This is done for each combination of the two prescale enables and for a zero count, so a wrong multiplier or a missing clamp shows up as a different cycle count. A single-cycle drop on a stop input partway through tells a restarting counter from one that pauses or ignores drops. A disabled lane held out of stop state, an enabled lane held out of stop state, and an empty enable mask together separate correct masking from masking that is missing or inverted. Holding stop high long before the set shows whether counters really stay at zero while the flag is low.

// File: rtl/lane_stop_pkg.sv
package lane_stop_pkg;
  localparam int unsigned PRE16_SH = 4;
  localparam int unsigned PRE4_SH  = 2;
  localparam int unsigned PRE_SH   = PRE16_SH + PRE4_SH;
endpackage

// File: rtl/stop_limit_calc.sv
module stop_limit_calc
  import lane_stop_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned LIM_W = CNT_W + PRE_SH
) (
  input  logic [CNT_W-1:0] tmo_count_i,
  input  logic             pre16_en_i,
  input  logic             pre4_en_i,
  output logic [LIM_W-1:0] limit_o
);
  logic [CNT_W-1:0] base;
  logic [LIM_W-1:0] wide;

  always_comb begin
    base = (tmo_count_i == '0) ? CNT_W'(1) : tmo_count_i;
    wide = LIM_W'(base);
    if (pre16_en_i) wide = wide << PRE16_SH;
    if (pre4_en_i)  wide = wide << PRE4_SH;
    limit_o = wide;
  end
endmodule

// File: rtl/lane_stop_qual.sv
module lane_stop_qual #(
  parameter int unsigned LIM_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             qual_o
);
  logic [LIM_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || !stop_i)  cnt_q <= '0;
    else if (cnt_q < limit_i)    cnt_q <= cnt_q + 1'b1;
  end

  // limit_i is never zero, so a cleared counter never qualifies
  assign qual_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/force_flag_ctl.sv
module force_flag_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic all_ok_i,
  output logic force_o,
  output logic done_o
);
  logic force_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (set_i) begin
        force_q <= 1'b1;
      end else if (force_q && all_ok_i) begin
        force_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  assign force_o = force_q;
  assign done_o  = done_q;
endmodule

// File: rtl/lane_stop_detect.sv
module lane_stop_detect
  import lane_stop_pkg::*;
#(
  parameter int unsigned NUM_LANES = 5,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 force_set_i,
  input  logic [NUM_LANES-1:0] lane_en_i,
  input  logic [NUM_LANES-1:0] lane_stop_i,
  input  logic [CNT_W-1:0]     tmo_count_i,
  input  logic                 pre16_en_i,
  input  logic                 pre4_en_i,
  output logic                 force_o,
  output logic [NUM_LANES-1:0] lane_qual_o,
  output logic                 done_o
);
  localparam int unsigned LIM_W = CNT_W + PRE_SH;

  logic [LIM_W-1:0]     limit;
  logic [NUM_LANES-1:0] qual;
  logic                 all_ok;

  stop_limit_calc #(.CNT_W(CNT_W)) u_limit (
    .tmo_count_i(tmo_count_i),
    .pre16_en_i (pre16_en_i),
    .pre4_en_i  (pre4_en_i),
    .limit_o    (limit)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_stop_qual #(.LIM_W(LIM_W)) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (force_o),
      .stop_i (lane_stop_i[g]),
      .limit_i(limit),
      .qual_o (qual[g])
    );
  end

  assign all_ok = &(qual | ~lane_en_i);

  force_flag_ctl u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (force_set_i),
    .all_ok_i(all_ok),
    .force_o (force_o),
    .done_o  (done_o)
  );

  assign lane_qual_o = qual;
endmodule

// File: rtl/lane_stop_detect_chk.sv
module lane_stop_detect_chk #(
  parameter int unsigned NUM_LANES = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 force_set_i,
  input logic [NUM_LANES-1:0] lane_en_i,
  input logic [NUM_LANES-1:0] lane_stop_i,
  input logic                 force_o,
  input logic [NUM_LANES-1:0] lane_qual_o,
  input logic                 done_o
);
  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_set_i |=> force_o);

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!force_o && $past(force_o)));

  p_qual_needs_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_qual_o != '0) |-> ((lane_qual_o & ~$past(lane_stop_i)) == '0));

  p_clear_needs_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(force_o) |-> ((($past(lane_qual_o) | ~$past(lane_en_i)) == '1)
                        && !$past(force_set_i)));

  p_qual_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_o && !$past(force_o)) |-> (lane_qual_o == '0));
endmodule

bind lane_stop_detect lane_stop_detect_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .force_set_i(force_set_i),
  .lane_en_i  (lane_en_i),
  .lane_stop_i(lane_stop_i),
  .force_o    (force_o),
  .lane_qual_o(lane_qual_o),
  .done_o     (done_o)
);

// File: tb/tb_lane_stop_detect.sv
module tb_lane_stop_detect;
  localparam int N = 5;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set = 1'b0;
  logic [N-1:0] en = '0, stop = '0;
  logic [CW-1:0] cnt = '0;
  logic x16 = 1'b0, x4 = 1'b0;
  logic force_w, done_w;
  logic [N-1:0] qual_w;

  int total = 0, bad = 0;
  int hi, dn;

  always #5 clk = ~clk;

  lane_stop_detect #(.NUM_LANES(N), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .force_set_i(set),
    .lane_en_i(en), .lane_stop_i(stop), .tmo_count_i(cnt),
    .pre16_en_i(x16), .pre4_en_i(x4),
    .force_o(force_w), .lane_qual_o(qual_w), .done_o(done_w)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [N-1:0] m, input logic [N-1:0] s,
                       input int c, input logic a16, input logic a4);
    @(negedge clk);
    en = m; stop = s; cnt = CW'(c); x16 = a16; x4 = a4;
  endtask

  // leaves time at the negedge right after the set edge
  task automatic pulse_set();
    @(negedge clk); set = 1'b1;
    @(negedge clk); set = 1'b0;
  endtask

  // counts high samples of force_o from the current negedge until it drops
  task automatic measure();
    hi = 0; dn = 0;
    for (int k = 0; k < 20000; k++) begin
      if (done_w) dn++;
      if (!force_w) break;
      hi++;
      @(negedge clk);
    end
    @(negedge clk);
    if (done_w) dn++;
  endtask

  task automatic t_reset();
    chk("R1 force", int'(force_w), 0);
    chk("R1 done", int'(done_w), 0);
    chk("R1 qual", int'(qual_w), 0);
  endtask

  task automatic t_timeout(input string req, input int c, input logic a16,
                           input logic a4, input int t);
    setup(5'b11111, 5'b11111, c, a16, a4);
    pulse_set();
    chk({req, " set"}, int'(force_w), 1);
    measure();
    chk({req, " high cycles"}, hi, t + 1);
    chk("R7 done once", dn, 1);
  endtask

  task automatic t_drop();
    setup(5'b00001, 5'b00001, 5, 1'b0, 1'b0);
    pulse_set();
    @(negedge clk);
    @(negedge clk); stop = 5'b00000;
    @(negedge clk); stop = 5'b00001;
    measure();
    chk("R5 restart", hi + 3, 9);
  endtask

  task automatic t_mask();
    setup(5'b00011, 5'b11011, 4, 1'b0, 1'b0);
    pulse_set();
    measure();
    chk("R6 disabled lane ignored", hi, 5);
    setup(5'b00011, 5'b00010, 4, 1'b0, 1'b0);
    pulse_set();
    repeat (6) @(negedge clk);
    chk("R9 qual per lane", int'(qual_w), 2);
    chk("R6 enabled lane blocks", int'(force_w), 1);
    stop = 5'b00011;
    measure();
    chk("R9 late lane", hi, 5);
  endtask

  task automatic t_empty_hold();
    setup(5'b00000, 5'b00000, 9, 1'b1, 1'b1);
    @(negedge clk); set = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 held set", int'(force_w), 1);
    @(negedge clk); set = 1'b0;
    hi = 3; dn = 0;
    @(negedge clk);
    chk("R6 empty mask clear", int'(force_w), 0);
    chk("R7 done empty", int'(done_w), 1);
    @(negedge clk);
    chk("R7 done one cycle", int'(done_w), 0);
  endtask

  task automatic t_idle();
    setup(5'b11111, 5'b11111, 6, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk("R8 idle qual", int'(qual_w), 0);
    chk("R8 idle force", int'(force_w), 0);
    pulse_set();
    measure();
    chk("R8 no pre-credit", hi, 7);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timeout("R3 plain", 3, 1'b0, 1'b0, 3);
        t_timeout("R3 x4", 2, 1'b0, 1'b1, 8);
        t_timeout("R3 x16", 2, 1'b1, 1'b0, 32);
        t_timeout("R3 both", 3, 1'b1, 1'b1, 192);
        t_timeout("R4 zero both", 0, 1'b1, 1'b1, 64);
        t_timeout("R4 zero plain", 0, 1'b0, 1'b0, 1);
        t_drop();
        t_mask();
        t_empty_hold();
        t_idle();
      end
      begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 1, 0);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule